// File: doc/BRIEF.md
# Multi-Mode Receive Comparator Decoder

This block sits behind a bank of three parallel slicing comparators per received symbol and turns their one-bit decisions into received data. A single mode input picks how the bank is read. In binary mode only the centre comparator matters and each symbol yields one bit. In four-level mode the three comparators act as a thermometer slicer, and their combined result becomes a two-bit Gray-coded symbol, which carries two bits per symbol at half the binary symbol rate. In speculative-feedback mode the upper and lower comparators are offset by plus and minus the expected first post-cursor interference. The previous decision then picks which of the two results to keep, so a mux replaces a feedback subtraction in the critical loop.

Each beat carries `LANES` consecutive symbols, with lane 0 the earliest. In speculative-feedback mode, lane k is chosen by the decision of lane k-1, and lane 0 is chosen by a stored decision from the last lane of the previous accepted beat. Input and output are valid/ready streams. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. The output beat is held stable while `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output register is empty or is being drained in that cycle, except during a mode-change cycle.

Top module: `sampler_decoder`

## Requirements
- R1: After reset, `out_valid` is 0, the stored previous decision is 0, and the registered mode is binary (code 0).
- R2: In binary mode (mode code 0), lane k outputs bit 2k = comparator bit 3k+1 and bit 2k+1 = 0. Comparator bits 3k and 3k+2 have no effect.
- R3: In four-level mode (mode code 1), lane k reads its comparators as code {c2,c1,c0} (c0 = bit 3k, the lowest threshold). Codes 000, 001, 011 and 111 give symbols 00, 01, 11 and 10 on bits [2k+1:2k].
- R4: In four-level mode, the non-thermometer codes 010, 100, 101 and 110 raise `out_bubble[k]`. They decode as the thermometer code with the same number of ones: 010 and 100 give 01, and 101 and 110 give 11.
- R5: In speculative-feedback mode (mode code 2), lane k outputs c2 if the previous decision is 1 and c0 if it is 0, on bit 2k, with bit 2k+1 = 0. The previous decision is lane k-1 for k>0 and the stored decision for lane 0. c1 has no effect.
- R6: The stored decision takes the last lane's decision only when a speculative-feedback beat is accepted. It keeps its value across idle cycles.
- R7: When `mode` differs from the registered mode, `in_ready` is 0 for that cycle. At the next edge `out_valid` clears, any held beat is dropped, and the stored decision resets to 0.
- R8: Mode code 3 decodes exactly as binary mode.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_bubble` stay stable and `in_ready` is 0.
- R10: With `out_ready` held at 1 and no mode change, `in_ready` stays 1 and one beat is accepted every cycle. Each accepted beat appears on the output one cycle later.
- R11: `out_bubble` is all zero in every mode other than four-level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 binary, 1 four-level, 2 speculative feedback, 3 as binary |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this edge when high with in_valid |
| in_cmp | input | 3*LANES | Comparator bits, lane k at [3k+2:3k] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts output beat |
| out_data | output | 2*LANES | Decoded bits, lane k at [2k+1:2k] |
| out_bubble | output | LANES | Per-lane non-thermometer flag |

## Verification
The embedded assertions watch several behaviours on every cycle:
- output stability under back-pressure;
- the one-cycle drop of `in_ready` and `out_valid` around a mode change;
- the clearing of the stored decision on a change, and its stability when no speculative beat is taken;
- the absence of bubble flags outside four-level mode.

The decode tables themselves, the lane-to-lane decision chaining, and the fact that a flushed decision really alters the next lane-0 choice can be shown only by the bench. It sweeps every comparator pattern of a beat in each mode against an arithmetic model and runs directed back-pressure and flush sequences.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;

  typedef enum logic [1:0] {
    MODE_BIN    = 2'd0,
    MODE_PAM4   = 2'd1,
    MODE_UNROLL = 2'd2,
    MODE_RSVD   = 2'd3
  } rx_mode_e;

  localparam int CMP_PER_LANE = 3;
  localparam int SYM_BITS     = 2;

endpackage

// File: rtl/rxdec_therm_lane.sv
module rxdec_therm_lane
  import rxdec_pkg::*;
(
  input  logic [CMP_PER_LANE-1:0] code,
  output logic [SYM_BITS-1:0]     sym,
  output logic                    bubble
);

  logic [1:0] ones;

  always_comb begin
    ones = 2'(code[0]) + 2'(code[1]) + 2'(code[2]);
    unique case (ones)
      2'd0:    sym = 2'b00;
      2'd1:    sym = 2'b01;
      2'd2:    sym = 2'b11;
      default: sym = 2'b10;
    endcase
    bubble = !(code == 3'b000 || code == 3'b001 ||
               code == 3'b011 || code == 3'b111);
  end

endmodule

// File: rtl/rxdec_unroll.sv
module rxdec_unroll #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             advance,
  input  logic [LANES-1:0] spec_hi,
  input  logic [LANES-1:0] spec_lo,
  output logic [LANES-1:0] dec,
  output logic             prev_q
);

  logic carry;

  always_comb begin
    carry = prev_q;
    for (int k = 0; k < LANES; k++) begin
      dec[k] = carry ? spec_hi[k] : spec_lo[k];
      carry  = dec[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (flush)   prev_q <= 1'b0;
    else if (advance) prev_q <= dec[LANES-1];
  end

  // R7: a flush leaves the stored decision at zero
  a_r7_prev_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (prev_q == 1'b0));

  // R6: without an accepted speculative beat the stored decision holds
  a_r6_prev_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !advance) |=> $stable(prev_q));

endmodule

// File: rtl/rxdec_stage.sv
module rxdec_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !flush && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (flush) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9: a stalled beat stays valid and unchanged
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid && $stable(out_data)));

  // R7: flushing empties the output register
  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

endmodule

// File: rtl/sampler_decoder.sv
module sampler_decoder
  import rxdec_pkg::*;
#(
  parameter int LANES = 4,
  localparam int CW = CMP_PER_LANE * LANES,
  localparam int DW = SYM_BITS * LANES,
  localparam int SW = DW + LANES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_cmp,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [LANES-1:0] out_bubble
);

  rx_mode_e mode_q;
  rx_mode_e eff_mode;
  logic     mode_chg;
  logic     advance;

  logic [LANES-1:0]               spec_hi, spec_lo, dec;
  logic [LANES-1:0][SYM_BITS-1:0] pam_sym, lane_data;
  logic [LANES-1:0]               pam_bub, lane_bub;
  logic                           prev_q;
  logic [SW-1:0]                  stage_in, stage_out;

  assign mode_chg = (rx_mode_e'(mode) != mode_q);
  assign eff_mode = (mode_q == MODE_RSVD) ? MODE_BIN : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BIN;
    else        mode_q <= rx_mode_e'(mode);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [CMP_PER_LANE-1:0] code;
    assign code       = in_cmp[CMP_PER_LANE*k +: CMP_PER_LANE];
    assign spec_hi[k] = code[2];
    assign spec_lo[k] = code[0];

    rxdec_therm_lane u_therm (
      .code   (code),
      .sym    (pam_sym[k]),
      .bubble (pam_bub[k])
    );

    always_comb begin
      unique case (eff_mode)
        MODE_PAM4: begin
          lane_data[k] = pam_sym[k];
          lane_bub[k]  = pam_bub[k];
        end
        MODE_UNROLL: begin
          lane_data[k] = {1'b0, dec[k]};
          lane_bub[k]  = 1'b0;
        end
        default: begin
          lane_data[k] = {1'b0, code[1]};
          lane_bub[k]  = 1'b0;
        end
      endcase
    end
  end

  assign advance = in_valid && in_ready && (eff_mode == MODE_UNROLL);

  rxdec_unroll #(.LANES(LANES)) u_unroll (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (mode_chg),
    .advance (advance),
    .spec_hi (spec_hi),
    .spec_lo (spec_lo),
    .dec     (dec),
    .prev_q  (prev_q)
  );

  assign stage_in = {lane_bub, lane_data};

  rxdec_stage #(.W(SW)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (mode_chg),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (stage_out)
  );

  assign out_data   = stage_out[DW-1:0];
  assign out_bubble = stage_out[SW-1:DW];

  // R11: bubble flags only leave the block in four-level mode
  a_r11_bubble_pam_only: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mode_q != MODE_PAM4) |-> (out_bubble == '0));

  // R7: the mode-change cycle refuses input
  a_r7_chg_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |-> !in_ready);

  // R10: an empty output with a steady mode always takes input
  a_r10_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !mode_chg) |-> in_ready);

endmodule

// File: tb/sampler_decoder_test.sv
module sampler_decoder_test;

  localparam int L      = 4;
  localparam int CW     = 3 * L;
  localparam int DW     = 2 * L;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [CW-1:0] in_cmp = '0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;
  logic [L-1:0]  out_bubble;

  int checks = 0;
  int errors = 0;
  logic bprev = 1'b0;
  logic done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  sampler_decoder #(.LANES(L)) uut (
    .clk, .rst_n, .mode, .in_valid, .in_ready, .in_cmp,
    .out_valid, .out_ready, .out_data, .out_bubble
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // model: returns {bubble, data}
  function automatic logic [CW-1:0] model(input int md, input logic [CW-1:0] c, inout logic p);
    logic [DW-1:0] d;
    logic [L-1:0]  b;
    d = '0; b = '0;
    for (int k = 0; k < L; k++) begin
      logic [2:0] cd;
      int n;
      cd = c[3*k +: 3];
      n = int'(cd[0]) + int'(cd[1]) + int'(cd[2]);
      if (md == 1) begin
        d[2*k +: 2] = (n == 0) ? 2'b00 : (n == 1) ? 2'b01 : (n == 2) ? 2'b11 : 2'b10;
        b[k] = !(cd == 3'b000 || cd == 3'b001 || cd == 3'b011 || cd == 3'b111);
      end else if (md == 2) begin
        d[2*k] = p ? cd[2] : cd[0];
        p = d[2*k];
      end else begin
        d[2*k] = cd[1];
      end
    end
    return {b, d};
  endfunction

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    in_valid = 1'b0;
    if (m != mode) begin
      mode = m;
      #1;
      check("R7 in_ready low on change", 64'(in_ready), 64'd0);
      @(negedge clk);
      check("R7 out_valid cleared", 64'(out_valid), 64'd0);
      bprev = 1'b0;
    end
  endtask

  // drive one beat at a negedge, check it at the following negedge
  task automatic send(input string tag, input logic [CW-1:0] c);
    logic [CW-1:0] e;
    in_valid = 1'b1;
    in_cmp = c;
    #1;
    check("R10 in_ready", 64'(in_ready), 64'd1);
    e = model(int'(mode), c, bprev);
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, {out_valid, out_bubble, out_data}, {1'b1, e});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out_valid after reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid idle", 64'(out_valid), 64'd0);
    check("R1 in_ready idle", 64'(in_ready), 64'd1);

    // exhaustive sweeps in every mode
    for (int m = 0; m < 4; m++) begin
      set_mode(2'(m));
      for (int v = 0; v < (1 << CW); v++) begin
        @(negedge clk);
        case (m)
          0: send("R2 binary sweep", CW'(v));
          1: send("R3 R4 four-level sweep", CW'(v));
          2: send("R5 speculative sweep", CW'(v));
          default: send("R8 reserved sweep", CW'(v));
        endcase
        if (m != 1) check("R11 no bubble", 64'(out_bubble), 64'd0);
      end
    end

    // R6: stored decision survives idle cycles
    set_mode(2'd2);
    @(negedge clk);
    send("R6 prime ones", {L{3'b101}});
    repeat (3) @(negedge clk);
    send("R6 lane0 uses stored one", CW'(3'b001));
    check("R6 lane0 bit", 64'(out_data[0]), 64'd0);

    // R7: flush clears the stored decision
    @(negedge clk);
    send("R7 prime ones", {L{3'b101}});
    set_mode(2'd0);
    set_mode(2'd2);
    @(negedge clk);
    send("R7 lane0 after flush", CW'(3'b001));
    check("R7 lane0 bit after flush", 64'(out_data[0]), 64'd1);

    // R9: back-pressure
    set_mode(2'd1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_cmp = {L{3'b011}};
    @(negedge clk);
    in_cmp = {L{3'b111}};
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R9 in_ready low while stalled", 64'(in_ready), 64'd0);
      check("R9 held data", {out_valid, out_data}, {1'b1, {L{2'b11}}});
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next beat after drain", {out_valid, out_data}, {1'b1, {L{2'b10}}});
    @(negedge clk);
    check("R10 output empties", 64'(out_valid), 64'd0);

    // R7: held beat dropped on mode change
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_cmp = '0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 beat held before change", 64'(out_valid), 64'd1);
    set_mode(2'd0);
    out_ready = 1'b1;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule